// File: doc/BRIEF.md
# Four-Slot Descriptor Queue with Completion Reports

This block is the per-channel descriptor queue of an audio-style DMA channel. Software pushes a descriptor into it as four 32-bit writes to one push address. The four words arrive in this order: buffer address low, buffer address high, byte length, flags. A descriptor is assembled from those writes, and only then does it enter a ring of four slots. A status word gives software both ring pointers, the full and empty conditions and a sticky error bit.

The transfer engine takes the oldest complete descriptor into an active-transfer register whenever that register is idle. When the engine reports that the active descriptor has finished, and the descriptor's notify flag is set, a completion report enters a second four-slot ring and a notify pulse is raised. Software drains each report with four reads from one pop address. A control bit holds both rings, and any half-assembled descriptor, in the cleared state.

Top module: `desc_ring_ctl`

## Requirements
- R1: After reset, both status words read 0x0000_0100 (empty set, pointers zero, error clear), `act_valid` is 0 and `notify` is 0.
- R2: A descriptor becomes visible only when its fourth word is written. After one to three words, the descriptor status is unchanged.
- R3: Descriptor words map as follows: word 0 goes to `act_addr[31:0]`, word 1 to `act_addr[63:32]`, word 2 to `act_len` and word 3 to `act_flags`.
- R4: The status word (descriptor at register 1, report at register 3) carries the write slot in bits [1:0], the read slot in bits [5:4], empty in bit 8, full in bit 9 and error in bit 10. Equal pointers mean 0 entries when empty is set and 4 entries when full is set.
- R5: Completing a fifth descriptor while four are queued sets the descriptor error bit and discards that descriptor. The queued four are unchanged.
- R6: Writing a status register with bit 10 set clears that ring's error bit. Writing it with bit 10 clear has no effect.
- R7: `take` moves the oldest descriptor into the active register and advances the read slot. This happens only when the active register is idle and the ring is not empty. Otherwise `take` is ignored.
- R8: `done` while active retires the descriptor. If `act_flags` bit 16 is set, a report {`done_count[31:0]`, `done_count[63:32]`, `done_extra`, `act_flags`} is queued and `notify` is high for exactly the following cycle. If bit 16 is clear, no report is queued and `notify` stays low.
- R9: Four reads of the report pop address (register 2) return count low, count high, extra and flags, in that order. The entry leaves the ring after the fourth read.
- R10: Reading the pop address while the report ring is empty returns 0 and sets the report error bit.
- R11: Writing 1 to control bit 0 (register 4) empties both rings and zeroes their pointers. It also clears both error bits and discards a partial descriptor. While the bit is 1, pushes are ignored and the bit reads back as 1.
- R12: `reg_rdata` holds the value of a read one clock after `reg_rd` is sampled, and keeps it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write register select |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Register read strobe |
| reg_raddr | input | 3 | Read register select |
| reg_rdata | output | 32 | Registered read data |
| take | input | 1 | Engine requests the next descriptor |
| act_valid | output | 1 | Active register holds a descriptor |
| act_addr | output | 64 | Active buffer address |
| act_len | output | 32 | Active byte length |
| act_flags | output | 32 | Active flags |
| done | input | 1 | Engine finished the active descriptor |
| done_count | input | 64 | Completion count for the report |
| done_extra | input | 32 | Extra report word |
| notify | output | 1 | One-cycle pulse when a report is queued |

## Verification
Every result appears one edge after its stimulus:
- Ring state from the fourth push word is readable through a status read that starts on the next cycle.
- The active register is valid in the cycle after `take`.
- `notify` rises in the cycle after `done` and falls one cycle later.
- Read data appears one edge after `reg_rd`.

The bench drives on the falling edge and samples on the next falling edge, so each check lands exactly on that edge. The one-cycle width of `notify` is confirmed by a second sample a cycle later.

// File: rtl/dring_pkg.sv
package dring_pkg;

    localparam int SLOTS     = 4;
    localparam int PTR_W     = $clog2(SLOTS);
    localparam int CNT_W     = PTR_W + 1;
    localparam int WORD_W    = 32;
    localparam int WORDS     = 4;
    localparam int IDX_W     = $clog2(WORDS);
    localparam int ENTRY_W   = WORDS * WORD_W;
    localparam int ADDR_W    = 3;

    localparam int ST_WR_LSB    = 0;
    localparam int ST_RD_LSB    = 4;
    localparam int ST_EMPTY_BIT = 8;
    localparam int ST_FULL_BIT  = 9;
    localparam int ST_ERR_BIT   = 10;
    localparam int NOTIFY_BIT   = 16;

    typedef enum logic [ADDR_W-1:0] {
        RA_DESC_PUSH = 3'd0,
        RA_DESC_STAT = 3'd1,
        RA_RPT_POP   = 3'd2,
        RA_RPT_STAT  = 3'd3,
        RA_CTRL      = 3'd4
    } reg_addr_e;

    // word 0 sits in the low bits
    typedef struct packed {
        logic [WORD_W-1:0] flags;
        logic [WORD_W-1:0] len;
        logic [WORD_W-1:0] addr_hi;
        logic [WORD_W-1:0] addr_lo;
    } desc_t;

    typedef struct packed {
        logic [WORD_W-1:0] flags;
        logic [WORD_W-1:0] extra;
        logic [WORD_W-1:0] cnt_hi;
        logic [WORD_W-1:0] cnt_lo;
    } rpt_t;

    function automatic logic [WORD_W-1:0] pack_status(
        input logic [PTR_W-1:0] wr,
        input logic [PTR_W-1:0] rd,
        input logic [CNT_W-1:0] cnt,
        input logic             err
    );
        logic [WORD_W-1:0] s;
        s = '0;
        s[ST_WR_LSB +: PTR_W] = wr;
        s[ST_RD_LSB +: PTR_W] = rd;
        s[ST_EMPTY_BIT]       = (cnt == '0);
        s[ST_FULL_BIT]        = (cnt == CNT_W'(SLOTS));
        s[ST_ERR_BIT]         = err;
        return s;
    endfunction

endpackage

// File: rtl/slot_ring.sv
module slot_ring
    import dring_pkg::*;
#(
    parameter int W = ENTRY_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [W-1:0] slot_q [SLOTS];
    logic         push_ok;
    logic         pop_ok;

    assign full    = (count == CNT_W'(SLOTS));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = slot_q[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(SLOTS - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) slot_q[wr_ptr] <= push_data;
    end

    assert_clear_empties_R11: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0) && (wr_ptr == '0) && (rd_ptr == '0));

    assert_ptr_span_R4: assert property (@(posedge clk) disable iff (rst)
        (count == '0 || count == CNT_W'(SLOTS)) |-> (wr_ptr == rd_ptr));

endmodule

// File: rtl/word_gather.sv
module word_gather
    import dring_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               stb,
    input  logic [WORD_W-1:0]  word,
    output logic               done,
    output logic [ENTRY_W-1:0] entry
);

    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] held [WORDS];

    assign done = stb && !clr && (idx == IDX_W'(WORDS - 1));

    for (genvar g = 0; g < WORDS; g++) begin : g_lane
        if (g == WORDS - 1) begin : g_last
            assign entry[g*WORD_W +: WORD_W] = word;
        end else begin : g_held
            assign entry[g*WORD_W +: WORD_W] = held[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx <= '0;
        end else if (stb) begin
            idx <= (idx == IDX_W'(WORDS - 1)) ? '0 : idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (stb) held[idx] <= word;
    end

endmodule

// File: rtl/word_scatter.sv
module word_scatter
    import dring_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               stb,
    input  logic               empty,
    input  logic [ENTRY_W-1:0] entry,
    output logic [WORD_W-1:0]  word,
    output logic               pop,
    output logic               underrun
);

    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] part [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_part
        assign part[g] = entry[g*WORD_W +: WORD_W];
    end

    assign word     = empty ? '0 : part[idx];
    assign pop      = stb && !empty && (idx == IDX_W'(WORDS - 1));
    assign underrun = stb && empty;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx <= '0;
        end else if (stb && !empty) begin
            idx <= (idx == IDX_W'(WORDS - 1)) ? '0 : idx + 1'b1;
        end
    end

endmodule

// File: rtl/desc_ring_ctl.sv
module desc_ring_ctl
    import dring_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_waddr,
    input  logic [WORD_W-1:0]  reg_wdata,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_raddr,
    output logic [WORD_W-1:0]  reg_rdata,
    input  logic               take,
    output logic               act_valid,
    output logic [63:0]        act_addr,
    output logic [WORD_W-1:0]  act_len,
    output logic [WORD_W-1:0]  act_flags,
    input  logic               done,
    input  logic [63:0]        done_count,
    input  logic [WORD_W-1:0]  done_extra,
    output logic               notify
);

    logic ring_clr;

    // descriptor side
    logic               g_stb, g_done;
    logic [ENTRY_W-1:0] g_entry;
    logic [ENTRY_W-1:0] d_head;
    logic [PTR_W-1:0]   d_wr, d_rd;
    logic [CNT_W-1:0]   d_cnt;
    logic               d_full, d_empty, d_err;
    logic               take_ok;
    desc_t              act_q;

    // report side
    logic               r_push, r_push_ok;
    rpt_t               r_new;
    logic [ENTRY_W-1:0] r_head;
    logic [PTR_W-1:0]   r_wr, r_rd;
    logic [CNT_W-1:0]   r_cnt;
    logic               r_full, r_empty, r_err;
    logic               s_stb, s_pop, s_under;
    logic [WORD_W-1:0]  s_word;

    logic wr_dstat_clr, wr_rstat_clr;

    assign g_stb   = reg_wr && (reg_waddr == RA_DESC_PUSH) && !ring_clr;
    assign take_ok = take && !act_valid && !d_empty && !ring_clr;
    assign s_stb   = reg_rd && (reg_raddr == RA_RPT_POP) && !ring_clr;

    assign wr_dstat_clr = reg_wr && (reg_waddr == RA_DESC_STAT) && reg_wdata[ST_ERR_BIT];
    assign wr_rstat_clr = reg_wr && (reg_waddr == RA_RPT_STAT)  && reg_wdata[ST_ERR_BIT];

    word_gather u_gather (
        .clk   (clk),
        .rst   (rst),
        .clr   (ring_clr),
        .stb   (g_stb),
        .word  (reg_wdata),
        .done  (g_done),
        .entry (g_entry)
    );

    slot_ring #(.W(ENTRY_W)) u_desc_ring (
        .clk       (clk),
        .rst       (rst),
        .clr       (ring_clr),
        .push      (g_done),
        .push_data (g_entry),
        .pop       (take_ok),
        .head      (d_head),
        .wr_ptr    (d_wr),
        .rd_ptr    (d_rd),
        .count     (d_cnt),
        .full      (d_full),
        .empty     (d_empty)
    );

    // control register: bit 0 holds both rings cleared
    always_ff @(posedge clk) begin
        if (rst) ring_clr <= 1'b0;
        else if (reg_wr && reg_waddr == RA_CTRL) ring_clr <= reg_wdata[0];
    end

    // descriptor error: set on overflow, cleared by ring clear or W1C
    always_ff @(posedge clk) begin
        if (rst || ring_clr)         d_err <= 1'b0;
        else if (g_done && d_full)   d_err <= 1'b1;
        else if (wr_dstat_clr)       d_err <= 1'b0;
    end

    // active transfer register
    always_ff @(posedge clk) begin
        if (rst) begin
            act_valid <= 1'b0;
            act_q     <= '0;
        end else if (take_ok) begin
            act_valid <= 1'b1;
            act_q     <= desc_t'(d_head);
        end else if (done && act_valid) begin
            act_valid <= 1'b0;
        end
    end

    assign act_addr  = {act_q.addr_hi, act_q.addr_lo};
    assign act_len   = act_q.len;
    assign act_flags = act_q.flags;

    // completion reports
    assign r_push        = done && act_valid && act_q.flags[NOTIFY_BIT] && !ring_clr;
    assign r_push_ok     = r_push && !r_full;
    assign r_new.cnt_lo  = done_count[31:0];
    assign r_new.cnt_hi  = done_count[63:32];
    assign r_new.extra   = done_extra;
    assign r_new.flags   = act_q.flags;

    slot_ring #(.W(ENTRY_W)) u_rpt_ring (
        .clk       (clk),
        .rst       (rst),
        .clr       (ring_clr),
        .push      (r_push),
        .push_data (r_new),
        .pop       (s_pop),
        .head      (r_head),
        .wr_ptr    (r_wr),
        .rd_ptr    (r_rd),
        .count     (r_cnt),
        .full      (r_full),
        .empty     (r_empty)
    );

    word_scatter u_scatter (
        .clk      (clk),
        .rst      (rst),
        .clr      (ring_clr),
        .stb      (s_stb),
        .empty    (r_empty),
        .entry    (r_head),
        .word     (s_word),
        .pop      (s_pop),
        .underrun (s_under)
    );

    always_ff @(posedge clk) begin
        if (rst || ring_clr)              r_err <= 1'b0;
        else if (s_under || (r_push && r_full)) r_err <= 1'b1;
        else if (wr_rstat_clr)            r_err <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) notify <= 1'b0;
        else     notify <= r_push_ok;
    end

    // registered read port
    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (reg_raddr)
                RA_DESC_STAT: reg_rdata <= pack_status(d_wr, d_rd, d_cnt, d_err);
                RA_RPT_STAT:  reg_rdata <= pack_status(r_wr, r_rd, r_cnt, r_err);
                RA_RPT_POP:   reg_rdata <= ring_clr ? '0 : s_word;
                RA_CTRL:      reg_rdata <= {{(WORD_W-1){1'b0}}, ring_clr};
                default:      reg_rdata <= '0;
            endcase
        end
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (g_done && d_full) |=> d_err);

    assert_partial_hidden_R2: assert property (@(posedge clk) disable iff (rst)
        (!g_done && !take_ok && !ring_clr) |=> $stable(d_cnt));

    assert_active_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (act_valid && !done) |=> (act_valid && $stable(act_addr) && $stable(act_flags)));

    assert_notify_cause_R8: assert property (@(posedge clk) disable iff (rst)
        notify |-> $past(done && act_valid && act_flags[NOTIFY_BIT]));

    assert_empty_read_R10: assert property (@(posedge clk) disable iff (rst)
        s_under |=> r_err);

endmodule

// File: tb/sim_desc_ring_ctl.sv
module sim_desc_ring_ctl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_waddr = '0, reg_raddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        take = 1'b0, done = 1'b0;
    logic        act_valid, notify;
    logic [63:0] act_addr;
    logic [31:0] act_len, act_flags;
    logic [63:0] done_count = '0;
    logic [31:0] done_extra = '0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #10 clk = ~clk;   // 50 MHz

    desc_ring_ctl u0 (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .take(take), .act_valid(act_valid), .act_addr(act_addr),
        .act_len(act_len), .act_flags(act_flags),
        .done(done), .done_count(done_count), .done_extra(done_extra),
        .notify(notify)
    );

    // {flags, len, addr_hi, addr_lo}
    localparam logic [127:0] VEC [4] = '{
        {32'h0001_0000, 32'h0000_0400, 32'h0000_0001, 32'h8000_0000},
        {32'h0000_0003, 32'h0000_0800, 32'h0000_0002, 32'h8000_1000},
        {32'h0001_00A5, 32'h0000_0200, 32'h0000_0003, 32'h8000_2000},
        {32'h0000_0000, 32'h0000_0100, 32'h0000_0004, 32'h8000_3000}
    };
    localparam logic [31:0] EXP_PUSH [4] = '{32'h001, 32'h002, 32'h003, 32'h200};
    localparam logic [31:0] EXP_TAKE [4] = '{32'h010, 32'h020, 32'h030, 32'h100};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_rd = 1'b1; reg_raddr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic push(input logic [127:0] d);
        for (int w = 0; w < 4; w++) wr(3'd0, d[w*32 +: 32]);
    endtask

    task automatic pulse_take();
        take = 1'b1;
        @(negedge clk);
        take = 1'b0;
    endtask

    function automatic logic [63:0] cnt_of(input int i);
        return 64'h0000_00AB_0000_0040 + 64'(i * 256);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 act_valid", 64'(act_valid), 64'd0);
        chk("R1 notify", 64'(notify), 64'd0);
        rd(3'd1, v); chk("R1 R12 desc status", 64'(v), 64'h100);
        rd(3'd3, v); chk("R1 report status", 64'(v), 64'h100);

        // table walk: pushes with status after each
        for (int i = 0; i < 4; i++) begin
            for (int w = 0; w < 4; w++) begin
                if (i == 0 && w == 3) begin
                    rd(3'd1, v); chk("R2 partial hidden", 64'(v), 64'h100);
                end
                wr(3'd0, VEC[i][w*32 +: 32]);
            end
            rd(3'd1, v); chk("R4 status after push", 64'(v), 64'(EXP_PUSH[i]));
        end

        // R5 fifth descriptor while full
        push({32'h0001_0000, 32'h0000_DEAD, 32'h0000_00FF, 32'hFFFF_0000});
        rd(3'd1, v); chk("R5 overflow error", 64'(v), 64'h600);
        // R6 W1C
        wr(3'd1, 32'h0000_0000);
        rd(3'd1, v); chk("R6 zero write no effect", 64'(v), 64'h600);
        wr(3'd1, 32'h0000_0400);
        rd(3'd1, v); chk("R6 W1C clears", 64'(v), 64'h200);

        // table walk: takes and completions
        for (int i = 0; i < 4; i++) begin
            pulse_take();
            chk("R7 act_valid", 64'(act_valid), 64'd1);
            chk("R3 addr", act_addr, {VEC[i][63:32], VEC[i][31:0]});
            chk("R3 len", 64'(act_len), 64'(VEC[i][95:64]));
            chk("R3 flags", 64'(act_flags), 64'(VEC[i][127:96]));
            if (i == 0) begin
                pulse_take();
                chk("R7 take while busy", act_addr, {VEC[0][63:32], VEC[0][31:0]});
            end
            rd(3'd1, v); chk("R7 status after take", 64'(v), 64'(EXP_TAKE[i]));
            done = 1'b1; done_count = cnt_of(i); done_extra = 32'hE000_0000 + 32'(i);
            @(negedge clk);
            done = 1'b0;
            chk("R8 notify", 64'(notify), 64'(VEC[i][96 + 16]));
            @(negedge clk);
            chk("R8 notify one cycle", 64'(notify), 64'd0);
            chk("R8 retired", 64'(act_valid), 64'd0);
        end

        // R7 take on empty ring
        pulse_take();
        chk("R7 take on empty", 64'(act_valid), 64'd0);

        // R9 report drain
        rd(3'd3, v); chk("R9 report status", 64'(v), 64'h002);
        for (int k = 0; k < 2; k++) begin
            int src;
            logic [63:0] c;
            src = (k == 0) ? 0 : 2;
            c = cnt_of(src);
            rd(3'd2, v); chk("R9 count lo", 64'(v), 64'(c[31:0]));
            rd(3'd2, v); chk("R9 count hi", 64'(v), 64'(c[63:32]));
            rd(3'd2, v); chk("R9 extra", 64'(v), 64'(32'hE000_0000 + 32'(src)));
            rd(3'd2, v); chk("R9 flags", 64'(v), 64'(VEC[src][127:96]));
            rd(3'd3, v); chk("R9 status after drain", 64'(v), (k == 0) ? 64'h012 : 64'h122);
        end

        // R10 read when empty
        rd(3'd2, v); chk("R10 empty read data", 64'(v), 64'd0);
        rd(3'd3, v); chk("R10 report error", 64'(v), 64'h522);

        // R11 ring reset, with a queued and a partial descriptor
        push(VEC[1]);
        wr(3'd0, 32'h1111_1111);
        wr(3'd0, 32'h2222_2222);
        wr(3'd4, 32'h1);
        rd(3'd4, v); chk("R11 control readback", 64'(v), 64'd1);
        push(VEC[2]);
        rd(3'd1, v); chk("R11 push ignored while held", 64'(v), 64'h100);
        wr(3'd4, 32'h0);
        rd(3'd1, v); chk("R11 desc cleared", 64'(v), 64'h100);
        rd(3'd3, v); chk("R11 report cleared", 64'(v), 64'h100);
        push(VEC[3]);
        pulse_take();
        chk("R11 partial discarded addr", act_addr, {VEC[3][63:32], VEC[3][31:0]});
        chk("R11 partial discarded len", 64'(act_len), 64'(VEC[3][95:64]));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule